// File: doc/BRIEF.md
# Processor Status Register with Event-Protected System Flags

This block is the status register of a small processor core. Its low field holds four arithmetic flags (carry, auxiliary carry, zero, overflow). The ALU side updates them through a strobe and a per-flag mask, so each operation touches only the flags it affects. An ordinary register write can also load them. Two general-purpose bits above the system flags are writable by software only.

Two system flags, a time-out flag and a power-down flag, cannot be changed by software at all. A register write silently skips them. They move only on four system event strobes: power-up, watchdog overflow, watchdog clear and halt. When several events arrive in one cycle, a fixed priority picks one of them. The register is read continuously through a single output byte. Saving status on a subroutine call is not done here; software must do it.

Top module: `stat_reg`

## Requirements
- R1: After reset (rst_n low) every bit of stat_q is 0.
- R2: A software write (wr_en high) leaves the power-down flag (stat_q[4]) and the time-out flag (stat_q[5]) unchanged, whatever wr_data[5:4] holds.
- R3: A software write loads stat_q[7:6] and stat_q[3:0] from the same bits of wr_data, visible one clock later.
- R4: With alu_upd high and no write, each flag i in 0..3 (0 carry, 1 auxiliary carry, 2 zero, 3 overflow; stored at stat_q[i]) takes alu_flags[i] when alu_mask[i] is 1 and holds when it is 0; stat_q[7:6] hold.
- R5: When alu_upd and wr_en are high in the same cycle, stat_q[3:0] take wr_data[3:0] and the ALU values are dropped.
- R6: ev_pwrup clears both the time-out and power-down flags, and overrides any other event in the same cycle.
- R7: ev_wdt_ovf without ev_pwrup sets the time-out flag and leaves the power-down flag unchanged, even if halt or clear arrive in the same cycle.
- R8: ev_halt without ev_pwrup or ev_wdt_ovf sets the power-down flag and clears the time-out flag.
- R9: ev_wdt_clr alone among the events clears both system flags.
- R10: In a cycle with no write, no ALU update and no event, stat_q holds its value.
- R11: System events leave stat_q[7:6] and stat_q[3:0] unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_upd | input | 1 | ALU flag update strobe |
| alu_mask | input | 4 | Flags affected by the current ALU operation |
| alu_flags | input | 4 | Flag values produced by the ALU |
| wr_en | input | 1 | Software register write strobe |
| wr_data | input | 8 | Software write data |
| ev_pwrup | input | 1 | Power-up event strobe |
| ev_wdt_ovf | input | 1 | Watchdog overflow event strobe |
| ev_wdt_clr | input | 1 | Watchdog clear event strobe |
| ev_halt | input | 1 | Halt event strobe |
| stat_q | output | 8 | Status register read value |

## Verification
The hardest case to reach from the ports is a write that tries to change a protected flag while that flag holds 1. Reset leaves both system flags at 0, so a write of zeros proves nothing. The stimulus first raises the power-down flag with a halt, or the time-out flag with a watchdog overflow. It then writes data whose bits 5:4 differ from the flags and checks that they survive. Simultaneous event strobes, and ALU/write collisions, are driven in single cycles to pin down each priority.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int STAT_W  = 8;
  localparam int FLAG_W  = 4;

  typedef enum logic [2:0] {
    SEV_NONE  = 3'd0,
    SEV_PWRUP = 3'd1,
    SEV_OVF   = 3'd2,
    SEV_HALT  = 3'd3,
    SEV_CLR   = 3'd4
  } sys_ev_e;

  typedef struct packed {
    logic tmo;
    logic pdn;
  } sys_flags_t;

  // Fixed priority: power-up, overflow, halt, clear.
  function automatic sys_ev_e pick_event(input logic pwrup, input logic ovf,
                                         input logic halt, input logic clr);
    if (pwrup)      return SEV_PWRUP;
    else if (ovf)   return SEV_OVF;
    else if (halt)  return SEV_HALT;
    else if (clr)   return SEV_CLR;
    else            return SEV_NONE;
  endfunction

  function automatic sys_flags_t sys_next(input sys_ev_e ev, input sys_flags_t cur);
    sys_flags_t n;
    n = cur;
    case (ev)
      SEV_PWRUP: begin n.tmo = 1'b0; n.pdn = 1'b0; end
      SEV_OVF:   begin n.tmo = 1'b1; end
      SEV_HALT:  begin n.tmo = 1'b0; n.pdn = 1'b1; end
      SEV_CLR:   begin n.tmo = 1'b0; n.pdn = 1'b0; end
      default:   ;
    endcase
    return n;
  endfunction

  // Per-bit next value of a software/ALU-writable bit; write has priority.
  function automatic logic field_bit_next(input logic cur, input logic wr, input logic wv,
                                          input logic upd, input logic aval);
    if (wr)       return wv;
    else if (upd) return aval;
    else          return cur;
  endfunction
endpackage

// File: rtl/stat_field_bits.sv
module stat_field_bits #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         upd_en,
  input  logic [W-1:0] upd_mask,
  input  logic [W-1:0] upd_val,
  output logic [W-1:0] q
);
  import stat_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_upd;
    logic bit_d;
    assign bit_upd = upd_en & upd_mask[i];
    assign bit_d   = field_bit_next(q[i], wr_en, wr_val[i], bit_upd, upd_val[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= bit_d;
    end
  end
endmodule

// File: rtl/stat_sys_flags.sv
module stat_sys_flags (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_pwrup,
  input  logic                 ev_wdt_ovf,
  input  logic                 ev_wdt_clr,
  input  logic                 ev_halt,
  output stat_pkg::sys_ev_e    sel_ev,
  output logic                 evt_any,
  output stat_pkg::sys_flags_t flags
);
  import stat_pkg::*;

  sys_flags_t flags_d;

  assign sel_ev  = pick_event(ev_pwrup, ev_wdt_ovf, ev_halt, ev_wdt_clr);
  assign evt_any = (sel_ev != SEV_NONE);
  assign flags_d = sys_next(sel_ev, flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end
endmodule

// File: rtl/stat_reg.sv
module stat_reg #(
  parameter int STAT_W = stat_pkg::STAT_W,
  parameter int FLAG_W = stat_pkg::FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_upd,
  input  logic [FLAG_W-1:0] alu_mask,
  input  logic [FLAG_W-1:0] alu_flags,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              ev_pwrup,
  input  logic              ev_wdt_ovf,
  input  logic              ev_wdt_clr,
  input  logic              ev_halt,
  output logic [STAT_W-1:0] stat_q
);
  import stat_pkg::*;

  localparam int PDN_POS = FLAG_W;
  localparam int TMO_POS = FLAG_W + 1;
  localparam int SPARE_W = STAT_W - FLAG_W - 2;
  localparam int SPARE_LO = FLAG_W + 2;

  logic [FLAG_W-1:0] arith_q;
  sys_flags_t        sys_q;
  sys_ev_e           sel_ev;
  logic              sys_evt_any;
  logic              wr_alu_collide;

  assign wr_alu_collide = wr_en & alu_upd;

  stat_field_bits #(.W(FLAG_W)) u_arith (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_val   (wr_data[FLAG_W-1:0]),
    .upd_en   (alu_upd),
    .upd_mask (alu_mask),
    .upd_val  (alu_flags),
    .q        (arith_q)
  );

  stat_sys_flags u_sys (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_pwrup   (ev_pwrup),
    .ev_wdt_ovf (ev_wdt_ovf),
    .ev_wdt_clr (ev_wdt_clr),
    .ev_halt    (ev_halt),
    .sel_ev     (sel_ev),
    .evt_any    (sys_evt_any),
    .flags      (sys_q)
  );

  assign stat_q[FLAG_W-1:0] = arith_q;
  assign stat_q[PDN_POS]    = sys_q.pdn;
  assign stat_q[TMO_POS]    = sys_q.tmo;

  if (SPARE_W > 0) begin : g_spare
    logic [SPARE_W-1:0] spare_q;
    stat_field_bits #(.W(SPARE_W)) u_spare (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_val   (wr_data[SPARE_LO +: SPARE_W]),
      .upd_en   (1'b0),
      .upd_mask ({SPARE_W{1'b0}}),
      .upd_val  ({SPARE_W{1'b0}}),
      .q        (spare_q)
    );
    assign stat_q[STAT_W-1:SPARE_LO] = spare_q;
  end
endmodule

// File: rtl/stat_reg_chk.sv
module stat_reg_chk #(
  parameter int STAT_W = 8,
  parameter int FLAG_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alu_upd,
  input logic              wr_en,
  input logic [STAT_W-1:0] wr_data,
  input logic              ev_pwrup,
  input logic              ev_wdt_ovf,
  input logic              ev_wdt_clr,
  input logic              ev_halt,
  input logic              sys_evt_any,
  input logic              wr_alu_collide,
  input logic [STAT_W-1:0] stat_q
);
  localparam int PDN_POS = FLAG_W;
  localparam int TMO_POS = FLAG_W + 1;
  localparam logic [STAT_W-1:0] SYS_MASK = (STAT_W'(3) << FLAG_W);
  localparam logic [STAT_W-1:0] WR_MASK  = ~SYS_MASK;

  // R2: a write alone keeps both protected flags
  a_r2_write_keeps_sys: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sys_evt_any) |=> ((stat_q & SYS_MASK) == ($past(stat_q) & SYS_MASK)));

  // R3 and R5: writable bits follow the written data, also on a collision
  a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((stat_q & WR_MASK) == ($past(wr_data) & WR_MASK)));

  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_alu_collide |=> (stat_q[FLAG_W-1:0] == $past(wr_data[FLAG_W-1:0])));

  a_r6_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pwrup |=> (!stat_q[TMO_POS] && !stat_q[PDN_POS]));

  a_r7_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wdt_ovf && !ev_pwrup) |=> (stat_q[TMO_POS] && $stable(stat_q[PDN_POS])));

  a_r8_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_halt && !ev_pwrup && !ev_wdt_ovf) |=> (stat_q[PDN_POS] && !stat_q[TMO_POS]));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wdt_clr && !ev_pwrup && !ev_wdt_ovf && !ev_halt) |=>
      (!stat_q[TMO_POS] && !stat_q[PDN_POS]));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !alu_upd && !sys_evt_any) |=> $stable(stat_q));

  a_r11_events_keep_data: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_evt_any && !wr_en && !alu_upd) |=>
      ((stat_q & WR_MASK) == ($past(stat_q) & WR_MASK)));
endmodule

bind stat_reg stat_reg_chk #(.STAT_W(STAT_W), .FLAG_W(FLAG_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .alu_upd        (alu_upd),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .ev_pwrup       (ev_pwrup),
  .ev_wdt_ovf     (ev_wdt_ovf),
  .ev_wdt_clr     (ev_wdt_clr),
  .ev_halt        (ev_halt),
  .sys_evt_any    (sys_evt_any),
  .wr_alu_collide (wr_alu_collide),
  .stat_q         (stat_q)
);

// File: tb/sim_stat_reg.sv
`timescale 1ns/1ps
module sim_stat_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alu_upd = 1'b0;
  logic [3:0] alu_mask = '0;
  logic [3:0] alu_flags = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ev_pwrup = 1'b0;
  logic       ev_wdt_ovf = 1'b0;
  logic       ev_wdt_clr = 1'b0;
  logic       ev_halt = 1'b0;
  logic [7:0] stat_q;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  stat_reg u0 (
    .clk(clk), .rst_n(rst_n), .alu_upd(alu_upd), .alu_mask(alu_mask),
    .alu_flags(alu_flags), .wr_en(wr_en), .wr_data(wr_data),
    .ev_pwrup(ev_pwrup), .ev_wdt_ovf(ev_wdt_ovf), .ev_wdt_clr(ev_wdt_clr),
    .ev_halt(ev_halt), .stat_q(stat_q)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] exp);
    total++;
    if (stat_q !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, stat_q, exp);
    end
  endtask

  // Apply the currently driven inputs for one edge, then release them.
  task automatic tick();
    @(posedge clk);
    #1;
    alu_upd = 0; alu_mask = '0; alu_flags = '0; wr_en = 0; wr_data = '0;
    ev_pwrup = 0; ev_wdt_ovf = 0; ev_wdt_clr = 0; ev_halt = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 reset", 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", 8'h00);
  endtask

  task automatic t_write();
    wr_en = 1; wr_data = 8'hFF; tick();
    check("R3 write all ones, R2 sys flags stay 0", 8'hCF);
    ev_halt = 1; tick();
    check("R8 halt sets pdn", 8'hDF);
    wr_en = 1; wr_data = 8'h20; tick();
    check("R2 write keeps pdn=1 and tmo=0", 8'h10);
    ev_wdt_ovf = 1; tick();
    check("R7 overflow sets tmo keeps pdn", 8'h30);
    wr_en = 1; wr_data = 8'h4A; tick();
    check("R2 write of zeros keeps both flags", 8'h7A);
  endtask

  task automatic t_alu();
    wr_en = 1; wr_data = 8'h00; tick();
    check("R3 clear writable", 8'h30);
    alu_upd = 1; alu_mask = 4'b0101; alu_flags = 4'b1111; tick();
    check("R4 masked update carry and zero", 8'h35);
    alu_upd = 1; alu_mask = 4'b1010; alu_flags = 4'b1000; tick();
    check("R4 overflow set, aux carry cleared", 8'h3D);
    alu_upd = 1; alu_mask = 4'b1111; alu_flags = 4'b0010; tick();
    check("R4 full update", 8'h32);
    alu_upd = 1; alu_mask = 4'b1111; alu_flags = 4'b1111;
    wr_en = 1; wr_data = 8'h84; tick();
    check("R5 write beats ALU", 8'hB4);
  endtask

  task automatic t_events();
    ev_wdt_clr = 1; tick();
    check("R9 clear both flags", 8'h84);
    ev_wdt_ovf = 1; ev_halt = 1; tick();
    check("R7 overflow over halt, pdn kept 0", 8'hA4);
    ev_halt = 1; ev_wdt_clr = 1; tick();
    check("R8 halt over clear", 8'h94);
    ev_wdt_ovf = 1; tick();
    check("R7 overflow with pdn set", 8'hB4);
    ev_pwrup = 1; ev_wdt_ovf = 1; ev_halt = 1; ev_wdt_clr = 1; tick();
    check("R6 power-up overrides all", 8'h84);
    ev_halt = 1; tick();
    ev_pwrup = 1; tick();
    check("R6 power-up clears pdn", 8'h84);
  endtask

  task automatic t_hold();
    ev_wdt_ovf = 1; tick();
    check("R11 events keep data bits", 8'hA4);
    repeat (3) @(negedge clk);
    check("R10 idle hold", 8'hA4);
    alu_upd = 1; alu_mask = 4'b0000; alu_flags = 4'b1111; tick();
    check("R4 empty mask holds flags", 8'hA4);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_write();
    t_alu();
    t_events();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule